// File: doc/BRIEF.md
# Data-Driven Enhanced Clock-Gated Register

This block is a register bank that stops its own clock when clocking it would change nothing. On every cycle the incoming word is compared bit by bit with the word already held. The clock reaches the register only under two conditions: at least one bit differs, and an explicit enable is high. When the enable is low, the clock is also held back during stretches where the data is changing. This keeps the flip-flops and the logic they drive quiet whenever the stored value would not move.

The gating decision is captured in a level-sensitive latch. The latch is transparent while the free-running clock is low and closed while it is high. The gated clock is the free-running clock ANDed with the latch output. An enable or data change that arrives during the high phase can therefore neither clip the current pulse nor add an extra one. A test-enable input forces the gate open so that the register loads on every cycle. A counter of gated-clock rising edges is brought out, so that a bench can see exactly how many pulses reached the register.

Top module: `ecg_reg`

## Requirements
- R1: The next word is compared with the stored word bit by bit. The differences are OR-reduced into a single change term, which is true when any bit differs.
- R2: With test-enable low, a rising clock edge whose sampled data equals the stored word produces no gated-clock edge. The edge counter stays unchanged.
- R3: With enable and test-enable both low, no gated-clock edge occurs and the stored word holds, whatever the data.
- R4: With enable high, test-enable low and data differing from the stored word, exactly one gated edge occurs on that clock cycle. The stored word then equals the sampled data.
- R5: With test-enable high, every clock cycle produces one gated edge and loads the data, regardless of enable and data.
- R6: The gating decision is fixed by the inputs present at the rising clock edge. An enable change during the high phase creates no extra pulse in that phase.
- R7: While the active-low asynchronous reset is asserted, the stored word and the edge counter are zero and no gated edge occurs.
- R8: The edge counter adds one per gated rising edge and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dIn | input | DATA_W | Next word to store |
| en | input | 1 | Explicit enable, 1 lets a changed word load |
| testEn | input | 1 | Test override, 1 forces the gate open |
| q | output | DATA_W | Stored word |
| edgeCount | output | CNT_W | Count of gated-clock rising edges |

## Verification
The bench sweeps every pair of stored word and next word of a 4-bit bank against all four enable and test-enable settings. Each step is preloaded through the test override, so the starting word is known. Equal pairs separate the data-driven gating from the enable gating. Differing pairs with the enable low show that the enable alone can block activity. The test-enable cases show that the override wins over both conditions. A separate step raises the enable inside the high phase, which would produce an extra pulse with a plain AND gate. The sweep runs the 6-bit counter through several wraps.

// File: rtl/ecg_pkg.sv
package ecg_pkg;
  // Strobes passed from gate control to datapath
  typedef struct packed {
    logic gatedClk;   // glitch-free gated clock
  } gateStrb_t;
endpackage

// File: rtl/ecg_change_detect.sv
module ecg_change_detect #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] nextWord,
  input  logic [DATA_W-1:0] heldWord,
  output logic              change
);
  localparam int LAST_BIT = DATA_W - 1;

  logic [LAST_BIT:0] diffBits;

  // R1: one XOR per bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_cmp
    assign diffBits[b] = nextWord[b] ^ heldWord[b];
  end

  // R1: OR reduction of per-bit differences
  assign change = |diffBits;
endmodule

// File: rtl/ecg_gate_ctrl.sv
module ecg_gate_ctrl
  import ecg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      change,
  input  logic      en,
  input  logic      testEn,
  output gateStrb_t strb
);
  logic wantOpen;
  logic latchQ;

  // Enhanced mode: data change AND explicit enable, override by test
  assign wantOpen = (change & en) | testEn;

  // Latch transparent in low phase, holds through high phase
  always_latch begin
    if (!rstN)
      latchQ = 1'b0;
    else if (!clk)
      latchQ = wantOpen;
  end

  assign strb.gatedClk = clk & latchQ;

  // Checker state: latch value seen at the rising edge
  logic openAtRise;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) openAtRise <= 1'b0;
    else       openAtRise <= latchQ;
  end

  AST_LATCH_STEADY: assert property (@(negedge clk) disable iff (!rstN)
    latchQ == openAtRise); // R6
endmodule

// File: rtl/ecg_datapath.sv
module ecg_datapath
  import ecg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] q,
  output logic [CNT_W-1:0]  edgeCount
);
  localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

  // Register bank on the gated clock
  always_ff @(posedge strb.gatedClk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= dIn;
  end

  // Activity counter, wraps naturally (R8)
  always_ff @(posedge strb.gatedClk or negedge rstN) begin
    if (!rstN) edgeCount <= '0;
    else       edgeCount <= edgeCount + CNT_STEP;
  end
endmodule

// File: rtl/ecg_reg.sv
module ecg_reg
  import ecg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic              en,
  input  logic              testEn,
  output logic [DATA_W-1:0] q,
  output logic [CNT_W-1:0]  edgeCount
);
  logic      change;
  gateStrb_t strb;

  ecg_change_detect #(.DATA_W(DATA_W)) u_cmp (
    .nextWord (dIn),
    .heldWord (q),
    .change   (change)
  );

  ecg_gate_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .change (change),
    .en     (en),
    .testEn (testEn),
    .strb   (strb)
  );

  ecg_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .rstN      (rstN),
    .strb      (strb),
    .dIn       (dIn),
    .q         (q),
    .edgeCount (edgeCount)
  );

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !testEn) |=> $stable(q)); // R3
  AST_LOAD_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (en || testEn) |=> q == $past(dIn)); // R4
  AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!testEn && (!en || dIn == q)) |=> $stable(edgeCount)); // R2
  AST_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    testEn |=> edgeCount == CNT_W'($past(edgeCount) + 1'b1)); // R5
endmodule

// File: tb/ecg_reg_test.sv
module ecg_reg_test;
  localparam int DW = 4;
  localparam int CW = 6;
  localparam int CMOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] dIn = '0;
  logic          en = 1'b0;
  logic          testEn = 1'b0;
  logic [DW-1:0] q;
  logic [CW-1:0] edgeCount;

  int errors = 0;
  int checks = 0;
  int refQ = 0;
  int refCnt = 0;
  int totalEdges = 0;

  ecg_reg #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .dIn(dIn), .en(en), .testEn(testEn),
    .q(q), .edgeCount(edgeCount)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive in low phase, sample 1 ns after the rising edge
  task automatic step(input int d, input bit e, input bit t);
    string tag;
    bit fire;
    @(negedge clk);
    dIn = DW'(d); en = e; testEn = t;
    fire = t || (e && (d != refQ));
    if (t)             tag = "R5";
    else if (!e)       tag = "R3";
    else if (d == refQ) tag = "R2";
    else               tag = "R1 R4";
    @(posedge clk);
    #1;
    if (fire) begin
      refQ = d;
      refCnt = (refCnt + 1) % CMOD;
      totalEdges++;
    end
    check({tag, " q"}, int'(q), refQ);
    check({tag, " edgeCount"}, int'(edgeCount), refCnt);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R7: reset holds everything at zero even with override on
    testEn = 1'b1; dIn = 4'hA;
    repeat (4) @(posedge clk);
    #1;
    check("R7 q", int'(q), 0);
    check("R7 edgeCount", int'(edgeCount), 0);
    @(negedge clk);
    testEn = 1'b0; dIn = '0;
    rstN = 1'b1;

    // Exhaustive sweep: stored word a, next word b, all control modes
    for (int a = 0; a < (1 << DW); a++) begin
      for (int b = 0; b < (1 << DW); b++) begin
        for (int m = 0; m < 4; m++) begin
          step(a, 1'b0, 1'b1);
          step(b, m[0], m[1]);
        end
      end
    end

    // R8: counter wrapped many times and still matches modulo count
    check("R8 wrapped", int'(totalEdges > CMOD), 1);
    check("R8 edgeCount", int'(edgeCount), totalEdges % CMOD);

    // R6: enable rises inside the high phase, no extra pulse now
    step(5, 1'b0, 1'b1);
    @(negedge clk);
    dIn = 4'd9; en = 1'b0; testEn = 1'b0;
    @(posedge clk);
    #2;
    en = 1'b1;
    #1;
    check("R6 q", int'(q), refQ);
    check("R6 edgeCount", int'(edgeCount), refCnt);
    // next cycle the raised enable takes effect
    @(posedge clk);
    #1;
    refQ = 9; refCnt = (refCnt + 1) % CMOD;
    check("R6 q next", int'(q), refQ);
    check("R6 edgeCount next", int'(edgeCount), refCnt);

    // R6: enable falls inside the high phase, pulse still completes
    @(negedge clk);
    dIn = 4'd3; en = 1'b1;
    @(posedge clk);
    #2;
    en = 1'b0;
    #2;
    refQ = 3; refCnt = (refCnt + 1) % CMOD;
    check("R6 q kept", int'(q), refQ);
    check("R6 edgeCount kept", int'(edgeCount), refCnt);

    // R7: asynchronous reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R7 async q", int'(q), 0);
    check("R7 async edgeCount", int'(edgeCount), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule